// File: doc/BRIEF.md
# Mixed-width dual-port RAM

A synchronous 4,608-bit memory with one write port and one read port. Each port picks its own word shape from a small fixed set through a 3-bit shape input: one bit, two bits, four bits, nine bits or eighteen bits per word. Both ports see the same storage. A value written four bits at a time can therefore be read back one bit at a time. Inside, the storage is 256 rows of 18 bits. An address is split into a row number and a slot within that row, according to the shape on that port.

A separate preload port writes whole 18-bit rows, ignoring any shape. With it the contents can be set up before normal use, so the block can serve as a ROM. The read data output is registered. Shapes of nine and eighteen bits use all 18 bits of each row. Shapes of one, two and four bits use only row bits 15:0, which gives 4,096 addressable bits. Mixing a 9- or 18-bit port with a 1-, 2- or 4-bit port is not a supported pairing.

Top module: `mwram`

## Requirements
- R1: A 4-bit word written at address A is read back through a 1-bit read at addresses 4A to 4A+3. Bit k of the word appears at address 4A+k, so the lowest address carries the least significant bit.
- R2: Shape codes are 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 9 bits and 4 = 18 bits. A word written and read back with the same shape comes back unchanged, at every shape.
- R3: With the wide shapes, an 18-bit word written at row R reads back through a 9-bit port as bits 8:0 at address 2R and bits 17:9 at address 2R+1.
- R4: With the narrow shapes, the row is the address divided by the words per row (16, 8 and 4 for codes 0, 1 and 2). The bit offset is the remainder times the width, inside row bits 15:0. The 1-bit shape reaches all 4,096 addresses, up to 4095.
- R5: rd_data takes the addressed word on the rd_clk edge at which rd_en is sampled high. While rd_en is low it holds its value, whatever rd_addr and rd_shape do.
- R6: A read and a write to the same location on the same clock edge return the data stored before that write.
- R7: rd_data bits at and above the read width are zero.
- R8: Address bits above the range of the selected shape are ignored. For example, an 18-bit port uses only address bits 7:0 and a 9-bit port only bits 8:0.
- R9: Shape codes 5 to 7 are reserved. A write with such a code changes no storage, and a read with such a code returns zero.
- R10: When pl_en is high, pl_data is written to the whole row pl_row on the wr_clk edge. On the same edge it takes priority over a normal write.
- R11: rd_data is zero after reset. Reset is rst_n, active low and asynchronous, and is released in step with rd_clk.
- R12: A write narrower than a row leaves every other bit of that row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write and preload clock |
| wr_shape | input | 3 | Write port shape code |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 12 | Write address in write-shape words |
| wr_data | input | 18 | Write data, low bits used |
| pl_en | input | 1 | Preload enable, full row |
| pl_row | input | 8 | Preload row number |
| pl_data | input | 18 | Preload row contents |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_shape | input | 3 | Read port shape code |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 12 | Read address in read-shape words |
| rd_data | output | 18 | Registered read data, zero-extended |

## Verification
The assertions expect rd_shape, rd_en, pl_en, pl_row and pl_data to be stable at each sampling edge. They also expect reset to be asserted long enough to fill the reset synchronizer. The stimulus drives every input on the falling clock edge and drives both clocks from one source. It never pairs a wide shape with a narrow shape over the same location, so each expected value comes from a single layout of the row. The storage is preloaded with a known pattern before any narrow access. This means no check depends on storage that was never written.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int unsigned ROW_W  = 18;
  localparam int unsigned NROWS  = 256;
  localparam int unsigned AW     = 12;
  localparam int unsigned SHW    = 3;
  localparam int unsigned RAW    = $clog2(NROWS);

  // shape codes
  localparam logic [SHW-1:0] SH_X1  = 3'd0;
  localparam logic [SHW-1:0] SH_X2  = 3'd1;
  localparam logic [SHW-1:0] SH_X4  = 3'd2;
  localparam logic [SHW-1:0] SH_X9  = 3'd3;
  localparam logic [SHW-1:0] SH_X18 = 3'd4;

  function automatic logic shape_valid(input logic [SHW-1:0] s);
    return s <= SH_X18;
  endfunction

  // data bits per word; zero for reserved codes
  function automatic int unsigned shape_width(input logic [SHW-1:0] s);
    case (s)
      SH_X1:   return 1;
      SH_X2:   return 2;
      SH_X4:   return 4;
      SH_X9:   return 9;
      SH_X18:  return 18;
      default: return 0;
    endcase
  endfunction

  // log2 of words held in one row
  function automatic int unsigned shape_slot_bits(input logic [SHW-1:0] s);
    case (s)
      SH_X1:   return 4;
      SH_X2:   return 3;
      SH_X4:   return 2;
      SH_X9:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] shape_mask(input logic [SHW-1:0] s);
    return ROW_W'((64'd1 << shape_width(s)) - 64'd1);
  endfunction

endpackage

// File: rtl/mwram_rst_sync.sv
module mwram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/mwram_wr_map.sv
module mwram_wr_map
  import mwram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SHW-1:0]   shape,
  input  logic [AW-1:0]    addr,
  input  logic [ROW_W-1:0] data,
  output logic [RAW-1:0]   row,
  output logic [ROW_W-1:0] mask,
  output logic [ROW_W-1:0] bits
);

  int unsigned     sb;
  int unsigned     w;
  int unsigned     shift;
  logic [AW-1:0]   slot;
  logic [ROW_W-1:0] base;

  always_comb begin
    sb    = shape_slot_bits(shape);
    w     = shape_width(shape);
    base  = shape_mask(shape);
    slot  = addr & AW'((32'd1 << sb) - 32'd1);
    shift = 32'(slot) * w;
    row   = RAW'(addr >> sb);
    mask  = base << shift;
    bits  = (data & base) << shift;
  end

  // R2
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shape_valid(shape) |-> ($countones(mask) == shape_width(shape)));

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shape_valid(shape) |-> (mask == '0));

  // R4
  narrow_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shape_valid(shape) && shape_width(shape) < 9) |-> (mask[ROW_W-1:16] == '0));

endmodule

// File: rtl/mwram_rd_sel.sv
module mwram_rd_sel
  import mwram_pkg::*;
(
  input  logic [SHW-1:0]   shape,
  input  logic [AW-1:0]    addr,
  input  logic [ROW_W-1:0] row_data,
  output logic [RAW-1:0]   row,
  output logic [ROW_W-1:0] word
);

  int unsigned   sb;
  int unsigned   shift;
  logic [AW-1:0] slot;

  always_comb begin
    sb    = shape_slot_bits(shape);
    slot  = addr & AW'((32'd1 << sb) - 32'd1);
    shift = 32'(slot) * shape_width(shape);
    row   = RAW'(addr >> sb);
    word  = (row_data >> shift) & shape_mask(shape);
  end

endmodule

// File: rtl/mwram.sv
module mwram
  import mwram_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic [SHW-1:0]   wr_shape,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ROW_W-1:0] wr_data,
  input  logic             pl_en,
  input  logic [RAW-1:0]   pl_row,
  input  logic [ROW_W-1:0] pl_data,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic [SHW-1:0]   rd_shape,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [ROW_W-1:0] rd_data
);

  logic [RAW-1:0]   wr_row;
  logic [ROW_W-1:0] wr_mask;
  logic [ROW_W-1:0] wr_bits;
  logic [RAW-1:0]   rd_row;
  logic [ROW_W-1:0] rd_word;
  logic [ROW_W-1:0] row_arr [NROWS];
  logic             rd_rst_n;
  logic [ROW_W-1:0] rd_data_q;
  logic [ROW_W-1:0] rd_data_d;

  mwram_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk        (rd_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rd_rst_n)
  );

  mwram_wr_map u_wr_map (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .shape (wr_shape),
    .addr  (wr_addr),
    .data  (wr_data),
    .row   (wr_row),
    .mask  (wr_mask),
    .bits  (wr_bits)
  );

  // storage rows: preload first, then masked write
  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_d;
    logic             row_we;

    always_comb begin
      row_we = 1'b0;
      row_d  = row_q;
      if (pl_en && (pl_row == RAW'(r))) begin
        row_we = 1'b1;
        row_d  = pl_data;
      end else if (wr_en && (wr_row == RAW'(r))) begin
        row_we = 1'b1;
        row_d  = (row_q & ~wr_mask) | wr_bits;
      end
    end

    always_ff @(posedge wr_clk) begin
      if (row_we) begin
        row_q <= row_d;
      end
    end

    assign row_arr[r] = row_q;
  end

  mwram_rd_sel u_rd_sel (
    .shape    (rd_shape),
    .addr     (rd_addr),
    .row_data (row_arr[rd_row]),
    .row      (rd_row),
    .word     (rd_word)
  );

  always_comb begin
    rd_data_d = rd_word;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;

  // R5
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data));

  // R7
  upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en |=> ((rd_data & ~shape_mask($past(rd_shape))) == '0));

  // R10
  preload_row_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    pl_en |=> (row_arr[$past(pl_row)] == $past(pl_data)));

endmodule

// File: tb/mwram_bench.sv
module mwram_bench;

  logic        clk = 1'b0;
  logic [2:0]  wr_shape;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [17:0] wr_data;
  logic        pl_en;
  logic [7:0]  pl_row;
  logic [17:0] pl_data;
  logic        rst_n;
  logic [2:0]  rd_shape;
  logic        rd_en;
  logic [11:0] rd_addr;
  logic [17:0] rd_data;

  always #2 clk = ~clk;

  mwram u_mwram (
    .wr_clk   (clk),
    .wr_shape (wr_shape),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pl_en    (pl_en),
    .pl_row   (pl_row),
    .pl_data  (pl_data),
    .rd_clk   (clk),
    .rst_n    (rst_n),
    .rd_shape (rd_shape),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;
  logic [17:0] mon_e;
  string       mon_t;
  logic [17:0] model [256];

  // expected layout from the requirements
  function automatic int bw(input logic [2:0] s);
    case (s)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 9;
      3'd4: return 18;
      default: return 0;
    endcase
  endfunction

  function automatic int bsb(input logic [2:0] s);
    case (s)
      3'd0: return 4;
      3'd1: return 3;
      3'd2: return 2;
      3'd3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [17:0] mget(input logic [2:0] s, input int a);
    int w   = bw(s);
    int row = (a >> bsb(s)) & 255;
    int sh  = (a & ((1 << bsb(s)) - 1)) * w;
    if (w == 0) return '0;
    return (model[row] >> sh) & 18'((1 << w) - 1);
  endfunction

  task automatic mput(input logic [2:0] s, input int a, input logic [17:0] d);
    int w   = bw(s);
    int row = (a >> bsb(s)) & 255;
    int sh  = (a & ((1 << bsb(s)) - 1)) * w;
    logic [17:0] m = 18'((1 << w) - 1) << sh;
    if (w != 0) model[row] = (model[row] & ~m) | ((d << sh) & m);
  endtask

  task automatic do_wr(input logic [2:0] s, input int a, input logic [17:0] d);
    @(negedge clk);
    wr_shape = s; wr_addr = 12'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    mput(s, a, d);
  endtask

  task automatic do_rd(input logic [2:0] s, input int a, input string tag);
    @(negedge clk);
    rd_shape = s; rd_addr = 12'(a); rd_en = 1'b1;
    exp_q.push_back(mget(s, a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic direct(input logic [17:0] act, input logic [17:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each captured read against the scoreboard
  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", rd_data);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if (rd_data !== mon_e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", mon_t, rd_data, mon_e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pl_en = 1'b0;
    wr_shape = '0; wr_addr = '0; wr_data = '0;
    rd_shape = '0; rd_addr = '0; pl_row = '0; pl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    direct(rd_data, 18'h0, "R11 reset value");

    // R10 preload every row
    for (int r = 0; r < 256; r++) begin
      pl_en = 1'b1; pl_row = 8'(r);
      pl_data = 18'((r * 18'h2A5) ^ 18'h15A5A);
      model[r] = pl_data;
      @(negedge clk);
    end
    pl_en = 1'b0;
    do_rd(3'd4, 0, "R10 preload row 0");
    do_rd(3'd4, 255, "R10 preload row 255");

    // R10 priority over a write to the same row
    @(negedge clk);
    pl_en = 1'b1; pl_row = 8'd7; pl_data = 18'h2C0DE;
    wr_en = 1'b1; wr_shape = 3'd4; wr_addr = 12'd7; wr_data = 18'h11111;
    @(negedge clk);
    pl_en = 1'b0; wr_en = 1'b0;
    model[7] = 18'h2C0DE;
    do_rd(3'd4, 7, "R10 preload priority");

    // R2 same-shape round trip
    for (int s = 0; s < 5; s++) begin
      do_wr(3'(s), 37 + s, 18'h3A5C7);
      do_rd(3'(s), 37 + s, "R2 roundtrip");
    end

    // R1 written 4 wide, read 1 wide, LSB at lowest address
    do_wr(3'd2, 5, 18'hA);
    for (int k = 0; k < 4; k++) do_rd(3'd0, 20 + k, "R1 R7 bit stream");

    // R4 top of narrow space
    do_wr(3'd0, 4092, 18'h1);
    do_wr(3'd0, 4093, 18'h0);
    do_wr(3'd0, 4094, 18'h1);
    do_wr(3'd0, 4095, 18'h1);
    do_rd(3'd2, 1023, "R4 nibble from bits");
    do_rd(3'd1, 2047, "R4 pair high");
    do_rd(3'd1, 2046, "R4 pair low");

    // R12 neighbours kept
    do_wr(3'd2, 401, 18'h6);
    do_rd(3'd2, 400, "R12 neighbour below");
    do_rd(3'd2, 402, "R12 neighbour above");
    do_rd(3'd2, 401, "R12 written nibble");

    // R3 wide row split in halves
    do_wr(3'd4, 40, 18'h2B3C5);
    do_rd(3'd3, 80, "R3 low half");
    do_rd(3'd3, 81, "R3 high half");
    do_wr(3'd3, 91, 18'h1F0);
    do_rd(3'd4, 45, "R12 R3 other half kept");

    // R8 high address bits ignored
    do_wr(3'd4, 12'hF05, 18'h1234F);
    do_rd(3'd4, 5, "R8 wide write alias");
    do_rd(3'd3, 12'hE0A, "R8 nine-bit read alias");

    // R9 reserved codes
    do_wr(3'd6, 300, 18'h3FFFF);
    do_rd(3'd0, 300, "R9 reserved write ignored");
    do_rd(3'd2, 75, "R9 reserved write ignored nibble");
    do_rd(3'd5, 300, "R9 reserved read zero");

    // R6 read and write together
    @(negedge clk);
    wr_shape = 3'd2; wr_addr = 12'd600; wr_data = 18'h9; wr_en = 1'b1;
    rd_shape = 3'd2; rd_addr = 12'd600; rd_en = 1'b1;
    exp_q.push_back(mget(3'd2, 600));
    tag_q.push_back("R6 old data on collision");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    mput(3'd2, 600, 18'h9);
    do_rd(3'd2, 600, "R6 new data after");

    // R5 hold while disabled
    do_rd(3'd4, 40, "R5 load");
    held = mget(3'd4, 40);
    rd_shape = 3'd0; rd_addr = 12'd21;
    repeat (3) @(negedge clk);
    direct(rd_data, held, "R5 hold while rd_en low");

    repeat (3) @(negedge clk);
    direct(18'(exp_q.size()), 18'h0, "scoreboard drained");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule